// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block is the control logic for a five-stage integer pipeline with fetch, decode, execute, memory and writeback stages. It takes the opcode class and the three register indices of the instruction now in decode, and it keeps its own record of the older instructions still in the pipeline. From these it works out whether decode must be held, whether a late branch must flush the younger stages, and which bypass path each execute operand takes. The datapath, the register file contents and the branch target arithmetic are outside the block. The only inputs are register indices, class bits and the branch condition that the datapath computes in the memory stage.

A static mode input picks one of two policies. With forwarding off, a consumer waits in decode until its producer reaches writeback. The register file writes in the first half of a cycle and reads in the second, so a consumer may read in the same cycle that its producer writes back. With forwarding on, ALU results are bypassed into execute. Only a load followed directly by its consumer costs one bubble. In both modes fetch continues sequentially past a branch. A taken branch is resolved in the memory stage, and it removes the three younger instructions in fetch, decode and execute.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Class codes on `id_cls` are 0 = none, 1 = register ALU (reads rs and rt, writes rd), 2 = immediate ALU (reads rs, writes rt), 3 = load (reads rs, writes rt), 4 = store (reads rs and rt), 5 = branch (reads rs and rt). Codes 6 and 7 act as none. A field that a class does not read never causes a stall.
- R2: Register index 0, used as a source or as a destination, never creates a dependence.
- R3: With `fwd_en` low, `stall` is high while a source of the decode instruction equals the destination of the instruction in execute or in memory.
- R4: With `fwd_en` low, a producer in writeback causes no stall, because the register file writes before it reads.
- R5: With `fwd_en` high, an ALU producer never stalls a consumer. A load followed directly by a consumer of its destination gives exactly one stall cycle.
- R6: `fwd_a` and `fwd_b` select for the execute instruction's rs and rt operands: 2'b10 takes the memory-stage result, 2'b01 takes the writeback-stage result, and 2'b00 takes the register file. The memory-stage result wins when both stages match. Both selects are 2'b00 when `fwd_en` is low.
- R7: A stall puts an empty slot into execute. The instruction held in decode is expected to be presented again on the next cycle.
- R8: `flush` is high in the cycle a branch sits in the memory stage with `mem_br_cond` high, and `mem_br_cond` is ignored otherwise. The instructions in fetch, decode and execute are then discarded.
- R9: When a flush and a stall are due in the same cycle, `flush` is high and `stall` is low.
- R10: Running the six-instruction loop (load, immediate add, store, pointer increment, subtract, branch if non-zero) gives one iteration every 17 cycles with forwarding off and every 10 cycles with forwarding on. Over 99 iterations, counted from the first fetch to the last writeback, the totals are 1684 and 991 cycles.
- R11: After reset the tracked pipeline is empty, and `stall`, `flush`, `fwd_a` and `fwd_b` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | Static policy select: 1 = forwarding, 0 = stall only |
| id_cls | input | 3 | Opcode class of the decode instruction |
| id_rs | input | 5 | rs field of the decode instruction |
| id_rt | input | 5 | rt field of the decode instruction |
| id_rd | input | 5 | rd field of the decode instruction |
| mem_br_cond | input | 1 | Branch condition computed for the memory-stage instruction |
| stall | output | 1 | Hold the PC and the decode register, and insert a bubble |
| flush | output | 1 | Discard fetch, decode and execute, and redirect fetch |
| fwd_a | output | 2 | Bypass select for the execute rs operand |
| fwd_b | output | 2 | Bypass select for the execute rt operand |

## Verification
The state that matters is the three-slot record of in-flight instructions. A slot that is wrong shows up within one to three cycles, depending on where it is. A lost bubble makes a stalled branch reach the memory stage one cycle early, so `flush` rises early. A slot that survives a flush shows up two cycles later as a bypass select that should be zero. A stale destination in execute or memory gives extra or missing `stall` cycles at once. Over a whole loop, any of these errors changes the iteration period away from 17 or 10 cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_W = 5;
    localparam int CLS_W = 3;
    localparam int SEL_W = 2;
    localparam int NUM_SRC = 2;

    typedef logic [REG_W-1:0] ridx_t;

    typedef enum logic [CLS_W-1:0] {
        CLS_NOP    = 3'd0,
        CLS_ALU_R  = 3'd1,
        CLS_ALU_I  = 3'd2,
        CLS_LOAD   = 3'd3,
        CLS_STORE  = 3'd4,
        CLS_BRANCH = 3'd5
    } icls_e;

    typedef enum logic [SEL_W-1:0] {
        FSEL_RF  = 2'b00,
        FSEL_WB  = 2'b01,
        FSEL_MEM = 2'b10
    } fsel_e;

    // One in-flight instruction, already reduced to the registers it really uses.
    typedef struct packed {
        icls_e cls;
        ridx_t src_a;
        ridx_t src_b;
        ridx_t dst;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '{cls: CLS_NOP, src_a: '0, src_b: '0, dst: '0};

    function automatic slot_t decode_slot(logic [CLS_W-1:0] cls, ridx_t rs, ridx_t rt, ridx_t rd);
        slot_t s;
        s = SLOT_EMPTY;
        case (icls_e'(cls))
            CLS_ALU_R:  begin s.cls = CLS_ALU_R;  s.src_a = rs; s.src_b = rt; s.dst = rd; end
            CLS_ALU_I:  begin s.cls = CLS_ALU_I;  s.src_a = rs; s.dst = rt; end
            CLS_LOAD:   begin s.cls = CLS_LOAD;   s.src_a = rs; s.dst = rt; end
            CLS_STORE:  begin s.cls = CLS_STORE;  s.src_a = rs; s.src_b = rt; end
            CLS_BRANCH: begin s.cls = CLS_BRANCH; s.src_a = rs; s.src_b = rt; end
            default:    s = SLOT_EMPTY;
        endcase
        return s;
    endfunction

    function automatic logic reg_hit(ridx_t src, ridx_t dst);
        return (src != '0) && (src == dst);
    endfunction

    function automatic logic depends_on(slot_t consumer, slot_t producer);
        return reg_hit(consumer.src_a, producer.dst) || reg_hit(consumer.src_b, producer.dst);
    endfunction

endpackage

// File: rtl/hz_track.sv
module hz_track
    import hz_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t id_slot,
    input  logic  stall,
    input  logic  flush,
    output slot_t ex_slot,
    output slot_t mem_slot,
    output slot_t wb_slot
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_slot  <= SLOT_EMPTY;
            mem_slot <= SLOT_EMPTY;
            wb_slot  <= SLOT_EMPTY;
        end else begin
            wb_slot <= mem_slot;
            if (flush) begin
                mem_slot <= SLOT_EMPTY;
                ex_slot  <= SLOT_EMPTY;
            end else begin
                mem_slot <= ex_slot;
                ex_slot  <= stall ? SLOT_EMPTY : id_slot;
            end
        end
    end

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (stall && !flush) |=> (ex_slot.cls == CLS_NOP)); // R7

    AST_FLUSH_KILLS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ex_slot.cls == CLS_NOP && mem_slot.cls == CLS_NOP)); // R8

endmodule

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fwd_en,
    input  slot_t id_slot,
    input  slot_t ex_slot,
    input  slot_t mem_slot,
    input  logic  mem_br_cond,
    output logic  stall,
    output logic  flush
);

    logic hazard;

    always_comb begin
        flush = (mem_slot.cls == CLS_BRANCH) && mem_br_cond;
        if (fwd_en)
            hazard = (ex_slot.cls == CLS_LOAD) && depends_on(id_slot, ex_slot);
        else
            hazard = depends_on(id_slot, ex_slot) || depends_on(id_slot, mem_slot);
        stall = hazard && !flush;
    end

    AST_LOADUSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && stall) |=> !stall); // R5

    AST_ALU_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && ex_slot.cls != CLS_LOAD) |-> !stall); // R5

endmodule

// File: rtl/hz_fwd.sv
module hz_fwd
    import hz_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fwd_en,
    input  slot_t                       ex_slot,
    input  slot_t                       mem_slot,
    input  slot_t                       wb_slot,
    output logic [N_SRC-1:0][SEL_W-1:0] sel
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        ridx_t src;
        assign src = (g == 0) ? ex_slot.src_a : ex_slot.src_b;

        always_comb begin
            if (!fwd_en)
                sel[g] = FSEL_RF;
            else if (reg_hit(src, mem_slot.dst))
                sel[g] = FSEL_MEM;
            else if (reg_hit(src, wb_slot.dst))
                sel[g] = FSEL_WB;
            else
                sel[g] = FSEL_RF;
        end

        AST_NO_MEM_FWD_OF_LOAD: assert property (@(posedge clk) disable iff (rst)
            (sel[g] == FSEL_MEM) |-> (mem_slot.cls != CLS_LOAD)); // R5
    end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hz_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fwd_en,
    input  logic [CLS_W-1:0] id_cls,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic [REG_W-1:0] id_rd,
    input  logic             mem_br_cond,
    output logic             stall,
    output logic             flush,
    output logic [SEL_W-1:0] fwd_a,
    output logic [SEL_W-1:0] fwd_b
);

    slot_t id_slot, ex_slot, mem_slot, wb_slot;
    logic [NUM_SRC-1:0][SEL_W-1:0] sel;

    assign id_slot = decode_slot(id_cls, id_rs, id_rt, id_rd);

    hz_track u_track (
        .clk      (clk),
        .rst      (rst),
        .id_slot  (id_slot),
        .stall    (stall),
        .flush    (flush),
        .ex_slot  (ex_slot),
        .mem_slot (mem_slot),
        .wb_slot  (wb_slot)
    );

    hz_detect u_detect (
        .clk         (clk),
        .rst         (rst),
        .fwd_en      (fwd_en),
        .id_slot     (id_slot),
        .ex_slot     (ex_slot),
        .mem_slot    (mem_slot),
        .mem_br_cond (mem_br_cond),
        .stall       (stall),
        .flush       (flush)
    );

    hz_fwd #(.N_SRC(NUM_SRC)) u_fwd (
        .clk      (clk),
        .rst      (rst),
        .fwd_en   (fwd_en),
        .ex_slot  (ex_slot),
        .mem_slot (mem_slot),
        .wb_slot  (wb_slot),
        .sel      (sel)
    );

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

endmodule

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, fwd_en, mem_br_cond;
    logic [2:0] id_cls;
    logic [4:0] id_rs, id_rt, id_rd;
    logic       stall, flush;
    logic [1:0] fwd_a, fwd_b;

    int checks = 0;
    int fails  = 0;
    int cyc_cnt = 0;

    pipe_hazard_ctrl dut_i (
        .clk(clk), .rst(rst), .fwd_en(fwd_en), .id_cls(id_cls), .id_rs(id_rs),
        .id_rt(id_rt), .id_rd(id_rd), .mem_br_cond(mem_br_cond),
        .stall(stall), .flush(flush), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    typedef struct {
        int raw; int rs; int rt; int rd;
        int cls; int a; int b; int d;
        bit tk; bit last;
    } rec_t;

    function automatic rec_t mk(int cls, int rs, int rt, int rd, bit tk, bit last);
        rec_t r;
        r.raw = cls; r.rs = rs; r.rt = rt; r.rd = rd;
        r.cls = 0; r.a = 0; r.b = 0; r.d = 0; r.tk = tk; r.last = last;
        case (cls)
            1: begin r.cls = 1; r.a = rs; r.b = rt; r.d = rd; end
            2: begin r.cls = 2; r.a = rs; r.d = rt; end
            3: begin r.cls = 3; r.a = rs; r.d = rt; end
            4: begin r.cls = 4; r.a = rs; r.b = rt; end
            5: begin r.cls = 5; r.a = rs; r.b = rt; end
            default: r.cls = 0;
        endcase
        return r;
    endfunction

    function automatic bit hit(int s, int d);
        return (s != 0) && (s == d);
    endfunction

    function automatic bit dep(rec_t c, rec_t p);
        return hit(c.a, p.d) || hit(c.b, p.d);
    endfunction

    function automatic int exp_sel(int s, rec_t m, rec_t w, bit f);
        if (!f) return 0;
        if (hit(s, m.d)) return 2;
        if (hit(s, w.d)) return 1;
        return 0;
    endfunction

    function automatic rec_t loop_instr(int i, bit tk, bit last);
        case (i)
            0: return mk(3, 2, 1, 0, 0, 0);
            1: return mk(2, 1, 1, 0, 0, 0);
            2: return mk(4, 2, 1, 0, 0, 0);
            3: return mk(2, 2, 2, 0, 0, 0);
            4: return mk(1, 3, 2, 4, 0, 0);
            default: return mk(5, 4, 0, 0, tk, last);
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(bit f);
        rst = 1'b1; fwd_en = f; mem_br_cond = 1'b1;
        id_cls = 3'd0; id_rs = 5'd0; id_rt = 5'd0; id_rd = 5'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drv(int cls, int rs, int rt, int rd, bit cond);
        @(negedge clk);
        id_cls = cls[2:0]; id_rs = rs[4:0]; id_rt = rt[4:0]; id_rd = rd[4:0];
        mem_br_cond = cond;
        #5;
    endtask

    task automatic run_engine(bit f, bit loopm, int ncyc, output int period, output int total);
        rec_t nop, ifid, ex, mem, wb, nx;
        int pc, brc, fetch1, fetch2;
        bit st_e, fl_e, stl, flh;
        nop = mk(0, 0, 0, 0, 0, 0);
        ifid = nop; ex = nop; mem = nop; wb = nop;
        pc = 0; brc = 0; fetch1 = -1; fetch2 = -1; total = -1;
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            id_cls = ifid.raw[2:0]; id_rs = ifid.rs[4:0]; id_rt = ifid.rt[4:0]; id_rd = ifid.rd[4:0];
            if (mem.cls == 5) mem_br_cond = mem.tk;
            else mem_br_cond = loopm ? 1'b0 : 1'($urandom % 2);
            #5;
            if (wb.last && total < 0) total = c;
            fl_e = (mem.cls == 5) && mem_br_cond;
            st_e = !fl_e && (f ? (ex.cls == 3 && dep(ifid, ex)) : (dep(ifid, ex) || dep(ifid, mem)));
            check(f ? "R5 stall" : "R3 stall", int'(stall), int'(st_e));
            check("R8 flush", int'(flush), int'(fl_e));
            check("R6 fwd_a", int'(fwd_a), exp_sel(ex.a, mem, wb, f));
            check("R6 fwd_b", int'(fwd_b), exp_sel(ex.b, mem, wb, f));
            stl = stall; flh = flush;
            wb = mem;
            if (flh) begin
                mem = nop; ex = nop; ifid = nop; pc = 0;
            end else begin
                mem = ex;
                if (stl) ex = nop;
                else begin
                    ex = ifid;
                    if (loopm) begin
                        if (pc < 6) begin
                            if (pc == 0) begin
                                if (fetch1 < 0) fetch1 = c;
                                else if (fetch2 < 0) fetch2 = c;
                            end
                            if (pc == 5) brc++;
                            nx = loop_instr(pc, brc < 99, brc == 99);
                            pc++;
                        end else nx = nop;
                    end else begin
                        nx = mk(int'($urandom % 8), int'($urandom % 4), int'($urandom % 4),
                                int'($urandom % 4), ($urandom % 3) == 0, 0);
                    end
                    ifid = nx;
                end
            end
            if (loopm && total >= 0) break;
        end
        period = fetch2 - fetch1;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int per, tot;
        void'($urandom(32'd4711));

        // R11: reset state, condition high with nothing in flight
        do_reset(1'b0);
        #5;
        check("R11 stall", int'(stall), 0);
        check("R11 flush", int'(flush), 0);
        check("R11 fwd_a", int'(fwd_a), 0);
        check("R11 fwd_b", int'(fwd_b), 0);

        // Stall-only policy
        do_reset(1'b0);
        drv(2, 0, 5, 0, 0); check("R3 no dep", int'(stall), 0);
        drv(1, 5, 0, 3, 0); check("R3 producer in EX", int'(stall), 1);
        drv(1, 5, 0, 3, 0); check("R3 producer in MEM", int'(stall), 1);
        drv(1, 5, 0, 3, 0); check("R4 producer in WB", int'(stall), 0);
        drv(2, 0, 0, 0, 0);
        drv(1, 0, 0, 2, 0); check("R2 register zero", int'(stall), 0);
        drv(2, 0, 6, 0, 0);
        drv(3, 1, 6, 0, 0); check("R1 load rt not a source", int'(stall), 0);
        drv(4, 0, 6, 0, 0); check("R1 store rt is a source", int'(stall), 1);
        drv(7, 6, 6, 6, 0); check("R1 class 7 reads nothing", int'(stall), 0);

        // Forwarding policy
        do_reset(1'b1);
        drv(2, 0, 7, 0, 0);
        drv(1, 7, 0, 1, 0); check("R5 ALU producer", int'(stall), 0);
        drv(0, 0, 0, 0, 0); check("R6 fwd_a from MEM", int'(fwd_a), 2);
        drv(2, 0, 8, 0, 0);
        drv(2, 0, 8, 0, 0);
        drv(1, 0, 8, 1, 0); check("R5 back to back", int'(stall), 0);
        drv(0, 0, 0, 0, 0); check("R6 MEM beats WB", int'(fwd_b), 2);
        drv(2, 0, 9, 0, 0);
        drv(0, 0, 0, 0, 0);
        drv(1, 9, 0, 1, 0);
        drv(0, 0, 0, 0, 0); check("R6 fwd_a from WB", int'(fwd_a), 1);

        // Load-use stall on a branch, then flush
        do_reset(1'b1);
        drv(3, 1, 9, 0, 0);
        drv(5, 9, 0, 0, 0); check("R5 load-use stall", int'(stall), 1);
        drv(5, 9, 0, 0, 1); check("R5 single stall", int'(stall), 0);
        check("R8 cond ignored without branch", int'(flush), 0);
        drv(3, 1, 10, 0, 1); check("R7 bubble keeps branch out of MEM", int'(flush), 0);
        drv(1, 10, 0, 1, 1); check("R8 taken branch in MEM", int'(flush), 1);
        check("R9 flush over stall", int'(stall), 0);
        drv(1, 10, 0, 1, 0); check("R8 no second flush", int'(flush), 0);
        drv(0, 0, 0, 0, 0); check("R8 EX instruction discarded", int'(fwd_a), 0);

        // R10: loop timing in both policies
        do_reset(1'b0);
        run_engine(1'b0, 1'b1, 2000, per, tot);
        check("R10 period no forwarding", per, 17);
        check("R10 total no forwarding", tot, 1684);
        do_reset(1'b1);
        run_engine(1'b1, 1'b1, 1200, per, tot);
        check("R10 period forwarding", per, 10);
        check("R10 total forwarding", tot, 991);

        // Random streams in both policies
        do_reset(1'b0);
        run_engine(1'b0, 1'b0, 3000, per, tot);
        do_reset(1'b1);
        run_engine(1'b1, 1'b0, 3000, per, tot);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule